// File: doc/BRIEF.md
# Halving-Tree Vector Sum Reducer

This block turns a stream of fixed-width vector chunks into one scalar total. It holds `LANES` independent running sums, one for each lane. After a start command it clears them. Each accepted chunk is then added lane by lane into the running sums. This lets a long input be fed in strips, with no serial dependence between lanes.

When the chunk flagged as last has been absorbed, the block collapses the running-sum vector. In each cycle it adds the upper half of the still-active lanes onto the lower half, and it repeats this until a single lane remains. It then presents that lane as the result, with a one-cycle valid pulse. All arithmetic is two's-complement integer addition that wraps at `W` bits, so the result equals the plain wrapped sum of every element of every chunk.

Top module: `vec_sum_halver`

## Requirements
- R1: After reset, `sum_valid` and `busy` are both low.
- R2: A `start` seen while idle clears all running sums to zero, and `busy` is high from the next cycle on.
- R3: While accumulating, each cycle with `chunk_valid` high adds lane i, taken from `chunk_data[i*W +: W]`, into running sum i.
- R4: A chunk accepted with `chunk_last` high ends accumulation. The block then runs exactly log2(LANES) halving passes, one per cycle, and each pass adds the upper half of the active lanes onto the lower half.
- R5: `sum_valid` rises log2(LANES) clock edges after the edge that accepted the last chunk. In that cycle `sum_out` equals the sum of all lanes of all accepted chunks.
- R6: Every addition wraps modulo 2^W.
- R7: `sum_valid` is high for exactly one cycle per job.
- R8: `start` is ignored while `busy` is high. It changes neither the result nor its timing.
- R9: `chunk_valid` is ignored while idle or during the halving passes.
- R10: `busy` is low in the cycle in which `sum_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new job: clear the sums and accept chunks |
| chunk_valid | input | 1 | `chunk_data` holds a chunk to add |
| chunk_last | input | 1 | Qualifies the current chunk as the final one |
| chunk_data | input | LANES*W | Packed lanes, lane i at bits i*W +: W |
| sum_valid | output | 1 | One-cycle pulse marking the result |
| sum_out | output | W | Scalar total, valid while `sum_valid` is high |
| busy | output | 1 | A job is accumulating or reducing |

## Verification
Any corruption of a running sum, whether a stale lane, a skipped clear or a pass that reads the wrong partner lane, shows up as a wrong `sum_out` on the very next valid pulse. This is because every lane feeds the final total. A length counter that halves the wrong number of times shows up as a valid pulse one or more cycles early or late, so the bench times each pulse exactly from the last accepted chunk. Ignored `start` and `chunk_valid` pulses inserted mid-job can only corrupt the total or shift that pulse, so both of those are checked.

// File: rtl/vec_sum_halver.sv
module vec_sum_halver #(
  parameter int LANES = 8,
  parameter int W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chunk_valid,
  input  logic               chunk_last,
  input  logic [LANES*W-1:0] chunk_data,
  output logic               sum_valid,
  output logic [W-1:0]       sum_out,
  output logic               busy
);
  localparam int LB = $clog2(LANES);
  localparam logic [LB:0] LEN_FULL = (LB+1)'(LANES);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_RED} state_t;

  state_t      state;
  logic [LB:0] len;
  logic [LB:0] half;
  logic        done;
  logic [W-1:0] acc [LANES];

  assign half      = len >> 1;
  assign busy      = (state != S_IDLE);
  assign sum_valid = done;
  assign sum_out   = acc[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      len   <= LEN_FULL;
      done  <= 1'b0;
      for (int i = 0; i < LANES; i++) acc[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_ACC;
          for (int i = 0; i < LANES; i++) acc[i] <= '0;
        end
        S_ACC: if (chunk_valid) begin
          for (int i = 0; i < LANES; i++) acc[i] <= acc[i] + chunk_data[i*W +: W];
          if (chunk_last) begin
            state <= S_RED;
            len   <= LEN_FULL;
          end
        end
        S_RED: begin
          for (int i = 0; i < LANES/2; i++)
            if (i < int'(half)) acc[i] <= acc[i] + acc[i + int'(half)];
          len <= half;
          if (half == 1) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |-> (!sum_valid && !busy));

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACC && !chunk_valid) |=> $stable(acc[0]));

  assert_len_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RED) |-> ($countones(len) == 1 && len > 1));

  assert_from_reduce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_valid) |-> $past(state == S_RED));

  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RED) |=> (state == S_RED || sum_valid));

  assert_idle_on_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> !busy);
endmodule

// File: tb/tb_vec_sum_halver.sv
module tb_vec_sum_halver;
  localparam int LANES = 8;
  localparam int W     = 16;
  localparam int LB    = $clog2(LANES);

  logic clk = 0, rst_n = 0, start = 0, chunk_valid = 0, chunk_last = 0;
  logic [LANES*W-1:0] chunk_data = '0;
  logic sum_valid, busy;
  logic [W-1:0] sum_out;

  int checks = 0, errors = 0;
  logic [LANES*W-1:0] chunks [8];

  vec_sum_halver #(.LANES(LANES), .W(W)) dut (.*);

  always #4 clk = ~clk;

  initial begin
    #1500000;
    errors++; checks++;
    $display("FAIL watchdog: run did not end (actual hung, expected done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model(int n);
    logic [W-1:0] s = '0;
    for (int c = 0; c < n; c++)
      for (int i = 0; i < LANES; i++) s += chunks[c][i*W +: W];
    return s;
  endfunction

  // n chunks; noise inserts ignored start/chunk_valid pulses
  task automatic run_job(int n, bit noise);
    int cyc;
    @(negedge clk);
    if (noise) begin
      chunk_valid = 1; chunk_data = {LANES{16'h1234}};   // R9: idle chunk ignored
    end
    @(negedge clk);
    chunk_valid = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R2 busy after start", busy, 1);
    for (int c = 0; c < n; c++) begin
      chunk_valid = 1; chunk_data = chunks[c]; chunk_last = (c == n-1);
      start = noise && (c == 0);                        // R8: start while busy
      @(negedge clk);
      start = 0; chunk_valid = 0; chunk_last = 0;
      if (noise && c != n-1) @(negedge clk);
    end
    cyc = 1;
    while (!sum_valid && cyc < 20) begin
      if (noise) begin chunk_valid = 1; start = 1; chunk_data = '1; end  // R8 R9
      @(negedge clk);
      chunk_valid = 0; start = 0;
      cyc++;
    end
    chk("R4 R5 pulse latency", cyc, LB + 1);
    chk("R5 R6 sum", sum_out, model(n));
    chk("R10 busy low on pulse", busy, 0);
    @(negedge clk);
    chk("R7 single pulse", sum_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    #2;
    chk("R1 reset valid", sum_valid, 0);
    chk("R1 reset busy", busy, 0);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < LANES; i++) chunks[0][i*W +: W] = W'(i + 1);
    run_job(1, 0);                                // R3 R4 single strip: 36
    chk("R4 lane weights", sum_out, 36);

    for (int c = 0; c < 2; c++) chunks[c] = {LANES{16'hFFFF}};
    run_job(2, 0);                                // R6 wrap: 0xFFF0
    chk("R6 wrap value", sum_out, 16'hFFF0);

    for (int c = 0; c < 3; c++) chunks[c] = '0;
    run_job(3, 0);                                // R2 cleared: zero result
    chk("R2 clear", sum_out, 0);

    for (int i = 0; i < LANES; i++) chunks[0][i*W +: W] = W'(1 << i);
    run_job(1, 1);                                // R8 R9 noise: 0xFF
    chk("R3 lane positions", sum_out, 16'h00FF);

    for (int j = 0; j < 25; j++) begin
      int n = 1 + ($urandom % 8);
      for (int c = 0; c < n; c++)
        for (int i = 0; i < LANES; i++) chunks[c][i*W +: W] = W'($urandom);
      run_job(n, j % 2 == 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule